// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block keeps the address and element counters of one DMA channel while data moves. A `start` strobe loads the channel from its configuration inputs and marks it running. Each completed bus beat then arrives as a strobe with the number of bytes it moved. The block turns that byte count into an element count and steps the current address by the signed inner stride. It also counts down the elements left in the current row.

When a row runs out, one of three things happens, depending on the configuration:
- In 2D mode with rows left, the block wraps to the next row. It takes back the last inner stride and adds the signed outer stride.
- In stop mode, the channel halts and reports completion.
- In any other mode, it asks an external descriptor fetcher for new settings and waits for `reload_done`.

An optional interrupt pulse marks the end of every row. A beat whose byte count is not a whole number of elements raises an error and freezes stepping.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset `run`, `reloading`, `curr_addr`, `curr_x`, `curr_y` and every pulse output are zero.
- R2: A `start` pulse sets `run`, loads `curr_addr` from `cfg_start_addr`, and loads `curr_x`/`curr_y` from `cfg_x_count`/`cfg_y_count`. A count of zero is loaded as 16'hFFFF.
- R3: The element size code is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. An accepted beat of B bytes moves N = B / size elements. `curr_addr` advances by N times the sign-extended `cfg_x_mod` and `curr_x` drops by N. A beat with B = 0 changes nothing.
- R4: Address arithmetic is 32 bits wide and wraps modulo 2^32.
- R5: When `curr_x` reaches zero, `row_irq` pulses for one cycle if `cfg_di_en` is 1, and stays low otherwise.
- R6: At a row end with `cfg_2d` = 1 and `curr_y` > 1, `curr_y` decrements, `curr_x` reloads from `cfg_x_count`, and `curr_addr` becomes the stepped address minus `cfg_x_mod` plus `cfg_y_mod`.
- R7: At any other row end with `cfg_flow` = 0 (stop), `run` clears and `done_set` and `run_clr` pulse together.
- R8: At any other row end with `cfg_flow` ≠ 0, `reload_req` pulses and `reloading` sets. Beats are ignored until `reload_done`, which reloads the channel as in R2.
- R9: A beat whose byte count is not a multiple of the element size pulses `err_set` and leaves the state unchanged. Later beats are then ignored until the next `start`, while `run` stays set.
- R10: Beats are ignored while `run` is clear.
- R11: A `start` or `reload_done` whose loaded start address is not a multiple of the element size pulses `err_set`. The load still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load the configuration and begin running |
| cfg_start_addr | input | 32 | First address |
| cfg_x_count | input | 16 | Elements per row (0 means 65535) |
| cfg_x_mod | input | 16 | Signed inner stride in bytes |
| cfg_y_count | input | 16 | Row count (0 means 65535) |
| cfg_y_mod | input | 16 | Signed outer stride in bytes |
| cfg_esz | input | 2 | Element size code |
| cfg_2d | input | 1 | Enable row wrapping |
| cfg_flow | input | 2 | Row-end policy: 0 stop, others reload |
| cfg_di_en | input | 1 | Enable the row-end interrupt |
| beat_vld | input | 1 | A bus beat completed |
| beat_bytes | input | 8 | Bytes moved by the beat |
| reload_done | input | 1 | New configuration is on the cfg inputs |
| curr_addr | output | 32 | Current address |
| curr_x | output | 16 | Elements left in the row |
| curr_y | output | 16 | Rows left |
| run | output | 1 | Channel running |
| reloading | output | 1 | Waiting for a descriptor reload |
| row_irq | output | 1 | Row-end interrupt pulse |
| done_set | output | 1 | Completion status pulse |
| err_set | output | 1 | Error status pulse |
| run_clr | output | 1 | Run-clear pulse |
| reload_req | output | 1 | Descriptor reload request pulse |

## Verification
The checks assume that a beat never carries more elements than `curr_x` still holds. They also assume that `reload_done` arrives only while `reloading` is set, and that the configuration inputs stay steady while the channel runs.

The stimulus keeps within these limits:
- Beat sizes are chosen so that rows end exactly.
- The configuration changes only between runs, or just before `reload_done`.
- Ignored-beat cases are driven in idle, halted and reloading states, so the invariants on stable state apply there.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_RUN    = 2'd1,
      ST_RELOAD = 2'd2,
      ST_HALT   = 2'd3
   } chan_state_e;

   localparam logic [1:0] FLOW_STOP = 2'd0;

   // size code to log2 of bytes, clamped to max_lg
   function automatic logic [1:0] esz_log2(input logic [1:0] code, input int max_lg);
      logic [1:0] lg;
      lg = (code >= 2'd2) ? 2'd2 : code;
      if (int'(lg) > max_lg) lg = 2'(max_lg);
      return lg;
   endfunction

endpackage

// File: rtl/dma2d_beat_decode.sv
module dma2d_beat_decode
   import dma2d_pkg::*;
#(
   parameter int BYTES_W    = 8,
   parameter int MAX_ESZ_LG = 2
) (
   input  logic [1:0]         esz_code,
   input  logic [BYTES_W-1:0] bytes,
   input  logic [1:0]         addr_lo,
   output logic [BYTES_W-1:0] elem_cnt,
   output logic               frac,
   output logic               misalign
);

   logic [1:0] lg;
   logic [1:0] mask;

   generate
      if (MAX_ESZ_LG == 0) begin : g_byte_only
         assign lg = 2'd0;
      end else begin : g_multi
         assign lg = esz_log2(esz_code, MAX_ESZ_LG);
      end
   endgenerate

   always_comb begin
      case (lg)
         2'd0:    mask = 2'b00;
         2'd1:    mask = 2'b01;
         default: mask = 2'b11;
      endcase
   end

   assign elem_cnt = bytes >> lg;
   assign frac     = |(bytes[1:0] & mask);
   assign misalign = |(addr_lo & mask);

endmodule

// File: rtl/dma2d_step.sv
module dma2d_step #(
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 16,
   parameter int MOD_W   = 16,
   parameter int BYTES_W = 8
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [CNT_W-1:0]   xcnt,
   input  logic [CNT_W-1:0]   ycnt,
   input  logic [BYTES_W-1:0] n,
   input  logic [MOD_W-1:0]   xmod,
   input  logic [MOD_W-1:0]   ymod,
   output logic [ADDR_W-1:0]  addr_step,
   output logic [ADDR_W-1:0]  addr_wrap,
   output logic [CNT_W-1:0]   x_step,
   output logic [CNT_W-1:0]   y_dec,
   output logic               row_end,
   output logic               rows_left
);

   localparam int EXT_W = ADDR_W - MOD_W;
   localparam int NPAD  = ADDR_W - BYTES_W;

   logic signed [ADDR_W-1:0] xm_ext;
   logic signed [ADDR_W-1:0] ym_ext;
   logic signed [ADDR_W-1:0] n_ext;
   logic        [ADDR_W-1:0] delta;

   assign xm_ext = $signed({{EXT_W{xmod[MOD_W-1]}}, xmod});
   assign ym_ext = $signed({{EXT_W{ymod[MOD_W-1]}}, ymod});
   assign n_ext  = $signed({{NPAD{1'b0}}, n});
   assign delta  = ADDR_W'(n_ext * xm_ext);

   assign addr_step = addr + delta;
   // undo the final inner stride, then apply the outer one
   assign addr_wrap = addr_step - ADDR_W'(xm_ext) + ADDR_W'(ym_ext);
   assign x_step    = xcnt - CNT_W'(n);
   assign y_dec     = ycnt - CNT_W'(1);
   assign row_end   = (xcnt == CNT_W'(n));
   assign rows_left = (ycnt > CNT_W'(1));

endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
   import dma2d_pkg::*;
(
   input  chan_state_e state,
   input  logic        start,
   input  logic        beat_vld,
   input  logic        reload_done,
   input  logic        frac,
   input  logic        zero_elems,
   input  logic        row_end,
   input  logic        rows_left,
   input  logic        mode_2d,
   input  logic        flow_stop,
   input  logic        di_en,
   output chan_state_e state_nx,
   output logic        do_load,
   output logic        do_step,
   output logic        do_wrap,
   output logic        irq_nx,
   output logic        done_nx,
   output logic        frac_nx,
   output logic        reload_nx
);

   logic accept;

   assign accept = (state == ST_RUN) && beat_vld && !start;

   always_comb begin
      state_nx  = state;
      do_load   = 1'b0;
      do_step   = 1'b0;
      do_wrap   = 1'b0;
      irq_nx    = 1'b0;
      done_nx   = 1'b0;
      frac_nx   = 1'b0;
      reload_nx = 1'b0;
      if (start) begin
         do_load  = 1'b1;
         state_nx = ST_RUN;
      end else if (state == ST_RELOAD && reload_done) begin
         do_load  = 1'b1;
         state_nx = ST_RUN;
      end else if (accept) begin
         if (frac) begin
            frac_nx  = 1'b1;
            state_nx = ST_HALT;
         end else if (!zero_elems) begin
            do_step = 1'b1;
            if (row_end) begin
               irq_nx = di_en;
               if (mode_2d && rows_left) begin
                  do_wrap = 1'b1;
               end else if (flow_stop) begin
                  done_nx  = 1'b1;
                  state_nx = ST_IDLE;
               end else begin
                  reload_nx = 1'b1;
                  state_nx  = ST_RELOAD;
               end
            end
         end
      end
   end

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
   import dma2d_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int MOD_W      = 16,
   parameter int BYTES_W    = 8,
   parameter int MAX_ESZ_LG = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  cfg_start_addr,
   input  logic [CNT_W-1:0]   cfg_x_count,
   input  logic [MOD_W-1:0]   cfg_x_mod,
   input  logic [CNT_W-1:0]   cfg_y_count,
   input  logic [MOD_W-1:0]   cfg_y_mod,
   input  logic [1:0]         cfg_esz,
   input  logic               cfg_2d,
   input  logic [1:0]         cfg_flow,
   input  logic               cfg_di_en,
   input  logic               beat_vld,
   input  logic [BYTES_W-1:0] beat_bytes,
   input  logic               reload_done,
   output logic [ADDR_W-1:0]  curr_addr,
   output logic [CNT_W-1:0]   curr_x,
   output logic [CNT_W-1:0]   curr_y,
   output logic               run,
   output logic               reloading,
   output logic               row_irq,
   output logic               done_set,
   output logic               err_set,
   output logic               run_clr,
   output logic               reload_req
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   initial begin
      if (ADDR_W <= MOD_W || ADDR_W <= BYTES_W)
         $error("ADDR_W must exceed MOD_W and BYTES_W");
      if (MAX_ESZ_LG < 0 || MAX_ESZ_LG > 2)
         $error("MAX_ESZ_LG must be 0..2");
      if (BYTES_W < 2)
         $error("BYTES_W must be at least 2");
   end

   chan_state_e        state_q, state_nx;
   logic [BYTES_W-1:0] elem_cnt;
   logic               frac, misalign;
   logic [ADDR_W-1:0]  addr_step, addr_wrap;
   logic [CNT_W-1:0]   x_step, y_dec;
   logic               row_end, rows_left;
   logic               do_load, do_step, do_wrap;
   logic               irq_nx, done_nx, frac_nx, reload_nx;
   logic [CNT_W-1:0]   x_ld, y_ld;

   assign x_ld = (cfg_x_count == '0) ? CNT_MAX : cfg_x_count;
   assign y_ld = (cfg_y_count == '0) ? CNT_MAX : cfg_y_count;

   dma2d_beat_decode #(.BYTES_W(BYTES_W), .MAX_ESZ_LG(MAX_ESZ_LG)) u_dec (
      .esz_code (cfg_esz),
      .bytes    (beat_bytes),
      .addr_lo  (cfg_start_addr[1:0]),
      .elem_cnt (elem_cnt),
      .frac     (frac),
      .misalign (misalign)
   );

   dma2d_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MOD_W(MOD_W), .BYTES_W(BYTES_W)) u_step (
      .addr      (curr_addr),
      .xcnt      (curr_x),
      .ycnt      (curr_y),
      .n         (elem_cnt),
      .xmod      (cfg_x_mod),
      .ymod      (cfg_y_mod),
      .addr_step (addr_step),
      .addr_wrap (addr_wrap),
      .x_step    (x_step),
      .y_dec     (y_dec),
      .row_end   (row_end),
      .rows_left (rows_left)
   );

   dma2d_ctrl u_ctrl (
      .state       (state_q),
      .start       (start),
      .beat_vld    (beat_vld),
      .reload_done (reload_done),
      .frac        (frac),
      .zero_elems  (elem_cnt == '0),
      .row_end     (row_end),
      .rows_left   (rows_left),
      .mode_2d     (cfg_2d),
      .flow_stop   (cfg_flow == FLOW_STOP),
      .di_en       (cfg_di_en),
      .state_nx    (state_nx),
      .do_load     (do_load),
      .do_step     (do_step),
      .do_wrap     (do_wrap),
      .irq_nx      (irq_nx),
      .done_nx     (done_nx),
      .frac_nx     (frac_nx),
      .reload_nx   (reload_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         curr_addr  <= '0;
         curr_x     <= '0;
         curr_y     <= '0;
         row_irq    <= 1'b0;
         done_set   <= 1'b0;
         err_set    <= 1'b0;
         run_clr    <= 1'b0;
         reload_req <= 1'b0;
      end else begin
         state_q    <= state_nx;
         row_irq    <= irq_nx;
         done_set   <= done_nx;
         run_clr    <= done_nx;
         reload_req <= reload_nx;
         err_set    <= frac_nx || (do_load && misalign);
         if (do_load) begin
            curr_addr <= cfg_start_addr;
            curr_x    <= x_ld;
            curr_y    <= y_ld;
         end else if (do_wrap) begin
            curr_addr <= addr_wrap;
            curr_x    <= x_ld;
            curr_y    <= y_dec;
         end else if (do_step) begin
            curr_addr <= addr_step;
            curr_x    <= x_step;
         end
      end
   end

   assign run       = (state_q != ST_IDLE);
   assign reloading = (state_q == ST_RELOAD);

endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              beat_vld,
   input logic              reload_done,
   input logic              cfg_di_en,
   input logic [ADDR_W-1:0] curr_addr,
   input logic [CNT_W-1:0]  curr_x,
   input logic              run,
   input logic              reloading,
   input logic              row_irq,
   input logic              done_set,
   input logic              err_set,
   input logic              run_clr,
   input logic              reload_req
);

   // R10
   idle_beat_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld && !run && !start) |=> ($stable(curr_addr) && $stable(curr_x)));

   // R8
   reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reloading && !reload_done && !start) |=> $stable(curr_addr));

   // R8
   reload_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req |-> reloading);

   // R5
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_irq |-> ($past(cfg_di_en) && $past(beat_vld)));

   // R7
   done_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_set |-> (!run && run_clr));

   // R9
   excl_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_set, reload_req, err_set}));

   // R2
   row_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !reloading) |-> (curr_x != '0));

endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .beat_vld    (beat_vld),
   .reload_done (reload_done),
   .cfg_di_en   (cfg_di_en),
   .curr_addr   (curr_addr),
   .curr_x      (curr_x),
   .run         (run),
   .reloading   (reloading),
   .row_irq     (row_irq),
   .done_set    (done_set),
   .err_set     (err_set),
   .run_clr     (run_clr),
   .reload_req  (reload_req)
);

// File: tb/test_dma2d_addr_gen.sv
module test_dma2d_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] cfg_start_addr = '0;
   logic [15:0] cfg_x_count = '0, cfg_x_mod = '0, cfg_y_count = '0, cfg_y_mod = '0;
   logic [1:0]  cfg_esz = '0, cfg_flow = '0;
   logic        cfg_2d = 1'b0, cfg_di_en = 1'b0;
   logic        beat_vld = 1'b0;
   logic [7:0]  beat_bytes = '0;
   logic        reload_done = 1'b0;
   logic [31:0] curr_addr;
   logic [15:0] curr_x, curr_y;
   logic        run, reloading, row_irq, done_set, err_set, run_clr, reload_req;

   always #5 clk = ~clk;

   dma2d_addr_gen i_dma2d_addr_gen (.*);

   typedef struct {
      string       req;
      logic [31:0] addr;
      logic [15:0] x, y;
      logic        run, rld_st, irq, done, err, rreq;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0, n_fail = 0;
   bit   finished = 0;
   logic chk_due = 1'b0;

   // reference model state
   logic [31:0] m_addr = '0;
   logic [15:0] m_x = '0, m_y = '0;
   logic        m_run = 0, m_rld = 0, m_halt = 0;

   function automatic int esz_bytes(input logic [1:0] c);
      return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
   endfunction

   function automatic logic [15:0] ld(input logic [15:0] c);
      return (c == 0) ? 16'hFFFF : c;
   endfunction

   task automatic push(input string r, input logic irq, input logic done,
                       input logic err, input logic rreq);
      exp_t e;
      e.req = r; e.addr = m_addr; e.x = m_x; e.y = m_y; e.run = m_run;
      e.rld_st = m_rld; e.irq = irq; e.done = done; e.err = err; e.rreq = rreq;
      exp_q.push_back(e);
   endtask

   task automatic model_load(output logic err);
      int es;
      es     = esz_bytes(cfg_esz);
      err    = (cfg_start_addr % es) != 0;
      m_addr = cfg_start_addr; m_x = ld(cfg_x_count); m_y = ld(cfg_y_count);
      m_run  = 1; m_rld = 0; m_halt = 0;
   endtask

   task automatic do_start(input string r);
      logic e;
      @(negedge clk);
      model_load(e);
      push(r, 0, 0, e, 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic do_reload(input string r);
      logic e;
      @(negedge clk);
      e = 0;
      if (m_rld) model_load(e);
      push(r, 0, 0, e, 0);
      reload_done = 1'b1;
      @(negedge clk);
      reload_done = 1'b0;
   endtask

   task automatic do_beat(input string r, input int bytes);
      int es, n;
      logic irq, done, err, rreq;
      logic [31:0] xm, ym;
      @(negedge clk);
      irq = 0; done = 0; err = 0; rreq = 0;
      es = esz_bytes(cfg_esz);
      xm = {{16{cfg_x_mod[15]}}, cfg_x_mod};
      ym = {{16{cfg_y_mod[15]}}, cfg_y_mod};
      if (m_run && !m_rld && !m_halt) begin
         if (bytes % es != 0) begin
            err = 1; m_halt = 1;
         end else if (bytes != 0) begin
            n = bytes / es;
            m_addr = m_addr + 32'(n) * xm;
            m_x = m_x - 16'(n);
            if (m_x == 0) begin
               irq = cfg_di_en;
               if (cfg_2d && m_y > 1) begin
                  m_y = m_y - 1; m_x = ld(cfg_x_count);
                  m_addr = m_addr - xm + ym;
               end else if (cfg_flow == 2'd0) begin
                  m_run = 0; done = 1;
               end else begin
                  m_rld = 1; rreq = 1;
               end
            end
         end
      end
      push(r, irq, done, err, rreq);
      beat_vld = 1'b1; beat_bytes = 8'(bytes);
      @(negedge clk);
      beat_vld = 1'b0; beat_bytes = '0;
   endtask

   task automatic cmp(input string r, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
      end
   endtask

   always @(posedge clk) chk_due <= beat_vld | start | reload_done;

   // monitor: pop and compare one cycle after each stimulus strobe
   always @(negedge clk) begin
      if (chk_due && exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         cmp(e.req, "addr", curr_addr, e.addr);
         cmp(e.req, "x", 32'(curr_x), 32'(e.x));
         cmp(e.req, "y", 32'(curr_y), 32'(e.y));
         cmp(e.req, "run", 32'(run), 32'(e.run));
         cmp(e.req, "reloading", 32'(reloading), 32'(e.rld_st));
         cmp(e.req, "row_irq", 32'(row_irq), 32'(e.irq));
         cmp(e.req, "done_set", 32'(done_set), 32'(e.done));
         cmp(e.req, "run_clr", 32'(run_clr), 32'(e.done));
         cmp(e.req, "err_set", 32'(err_set), 32'(e.err));
         cmp(e.req, "reload_req", 32'(reload_req), 32'(e.rreq));
      end
   end

   task automatic cfg(input logic [31:0] a, input int xc, input int xmv, input int yc,
                      input int ymv, input int esz, input bit d2, input int fl, input bit di);
      cfg_start_addr = a; cfg_x_count = 16'(xc); cfg_x_mod = 16'(xmv);
      cfg_y_count = 16'(yc); cfg_y_mod = 16'(ymv); cfg_esz = 2'(esz);
      cfg_2d = d2; cfg_flow = 2'(fl); cfg_di_en = di;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      cmp("R1", "run", 32'(run), 0);
      cmp("R1", "addr", curr_addr, 0);
      cmp("R1", "pulses", 32'({row_irq, done_set, err_set, run_clr, reload_req, reloading}), 0);
      rst_n = 1'b1;

      // R10 beat while idle is ignored
      cfg(32'h1000, 4, 4, 1, 0, 2, 0, 0, 1);
      do_beat("R10", 4);

      // R2 R3 1D run of 4-byte elements, stop mode
      do_start("R2");
      do_beat("R3", 4);
      do_beat("R3", 8);
      do_beat("R3 zero", 0);
      do_beat("R7 R5", 4);

      // R3 negative stride with 2-byte elements, no interrupt
      cfg(32'h100, 3, -2, 1, 0, 1, 0, 0, 0);
      do_start("R2");
      do_beat("R3 neg", 2);
      do_beat("R3 neg", 4);

      // R6 2D wrap with 1-byte elements
      cfg(32'h200, 3, 1, 2, 10, 0, 1, 0, 1);
      do_start("R2");
      do_beat("R6", 3);
      do_beat("R6", 2);
      do_beat("R7", 1);

      // R4 address wrap
      cfg(32'hFFFF_FFFE, 2, 4, 1, 0, 0, 0, 0, 0);
      do_start("R4");
      do_beat("R4", 1);

      // R9 fractional beat halts stepping
      cfg(32'h400, 4, 4, 1, 0, 2, 0, 0, 1);
      do_start("R2");
      do_beat("R9", 3);
      do_beat("R9 halted", 4);

      // R8 descriptor reload flow
      cfg(32'h500, 2, 4, 1, 0, 2, 0, 1, 1);
      do_start("R2");
      do_beat("R8", 8);
      do_beat("R8 ignored", 4);
      cfg(32'h800, 1, 4, 1, 0, 2, 0, 0, 1);
      do_reload("R8");
      do_beat("R8 after", 4);

      // R2 zero counts load as max
      cfg(32'h900, 0, 1, 0, 0, 0, 0, 0, 0);
      do_start("R2 zero");
      do_beat("R3", 5);

      // R11 misaligned start address
      cfg(32'h902, 2, 4, 1, 0, 2, 0, 0, 0);
      do_start("R11");

      repeat (3) @(negedge clk);
      cmp("queue", "pending", 32'(exp_q.size()), 0);
      summary();
   end

endmodule